// File: doc/BRIEF.md
# Four-Channel Timer Capture Unit

This block freezes the value of a free-running 16-bit timer into one of four capture registers whenever that channel is triggered. A channel runs in one of two modes. In pin mode, a chosen edge on the channel's input pin starts the capture. The pin first passes through a two-stage synchroniser. In write mode, software starts the capture by writing the channel's low-byte address. The byte written is thrown away, and the register takes the live timer count instead.

Every capture raises a sticky per-channel interrupt flag, and software clears the flag by writing 1 to it. Software reads the capture registers and the flags one byte at a time over a small address/data bus. The timer itself is outside the block and arrives on an input.

Top module: `cap4_unit`

## Requirements
- R1: After reset, every capture register and every interrupt flag is 0, and a read of any address returns 0.
- R2: With sw_mode[c]=0 and fall_edge[c]=0, a rising edge on pin_i[c] captures timer_i into channel c, and a falling edge captures nothing.
- R3: With sw_mode[c]=0 and fall_edge[c]=1, a falling edge on pin_i[c] captures timer_i into channel c, and a rising edge captures nothing.
- R4: With sw_mode[c]=1, a write to address 2c loads the timer_i value present at that clock edge into channel c, visible after that edge. The data byte is discarded.
- R5: With sw_mode[c]=1, pin edges on channel c have no effect. With sw_mode[c]=0, a write to address 2c has no effect. A write to the high-byte address 2c+1 never changes a register.
- R6: A capture register holds its value, whatever the timer does, until that channel's next trigger.
- R7: Reads are combinational. Address 2c returns bits 7:0 of channel c, address 2c+1 returns bits 15:8, address 8 returns the flags in bits 3:0 (bit c = channel c), and any other address returns 0.
- R8: Each capture sets irq_o[c], and the flag stays set until a write to address 8 with data bit c = 1. Bits written as 0 leave their flags alone. A capture in the same cycle as a clear leaves the flag set.
- R9: A pin-mode capture takes the timer_i value present at the third rising clock edge after the pin changes. The register is still unchanged after the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | 4 | Asynchronous capture pins, one per channel |
| timer_i | input | 16 | Live timer count |
| sw_mode | input | 4 | Per-channel mode: 1 = write-triggered, 0 = pin-triggered |
| fall_edge | input | 4 | Per-channel pin edge: 1 = falling, 0 = rising |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 4 | Byte address for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| cap_o | output | 64 | Capture registers, channel c in bits 16c+15:16c |
| irq_o | output | 4 | Sticky capture flags |

## Verification
The bench walks every channel through both modes and both edge polarities. Between the trigger edge and the opposite edge it swaps the timer value, so a design that captured on the wrong edge would end up holding the decoy value. It checks the exact cycle of a pin capture: one synchroniser stage too few or too many would show the new value an edge early or an edge late.

Other tests cover the inputs that must be ignored. These are writes in pin mode, pins in write mode, and high-byte writes, and a design that obeyed any of them would change a frozen register. A clear is timed to land in the same cycle as a capture, so a design that gave the clear priority would lose that capture's flag. A partial clear checks that flags written as 0 survive.

// File: rtl/cap4_unit.sv
`timescale 1ns/1ps
module cap4_unit #(
  parameter int NCH = 4,
  parameter int TW  = 16,
  parameter int AW  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    pin_i,
  input  logic [TW-1:0]     timer_i,
  input  logic [NCH-1:0]    sw_mode,
  input  logic [NCH-1:0]    fall_edge,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic [NCH*TW-1:0] cap_o,
  output logic [NCH-1:0]    irq_o
);
  localparam int FLAG_ADDR = 2 * NCH;

  logic [NCH-1:0] sy1, sy2, sy3;
  logic [NCH-1:0] trig, irq_q, clr;
  logic [TW-1:0]  cap_q [NCH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sy1 <= '0;
      sy2 <= '0;
      sy3 <= '0;
    end else begin
      sy1 <= pin_i;
      sy2 <= sy1;
      sy3 <= sy2;
    end
  end

  wire [NCH-1:0] rise    = sy2 & ~sy3;
  wire [NCH-1:0] fall    = ~sy2 & sy3;
  wire           flag_wr = bus_we && (bus_addr == AW'(FLAG_ADDR));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    wire lo_wr = bus_we && (bus_addr == AW'(2 * c));
    assign trig[c] = sw_mode[c] ? lo_wr : (fall_edge[c] ? fall[c] : rise[c]);
    assign clr[c]  = flag_wr && bus_wdata[c];

    always_ff @(posedge clk) begin
      if (!rst_n)       cap_q[c] <= '0;
      else if (trig[c]) cap_q[c] <= timer_i;
    end

    assign cap_o[c*TW +: TW] = cap_q[c];

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !trig[c] |=> $stable(cap_q[c]));
    p_swcap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_mode[c] && lo_wr) |=> cap_q[c] == $past(timer_i));
    p_pin_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_mode[c] && !lo_wr) |=> $stable(cap_q[c]));
    p_rise_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_mode[c] && !fall_edge[c] && sy2[c] && !sy3[c]) |=> cap_q[c] == $past(timer_i));
    p_fall_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_mode[c] && fall_edge[c] && !sy2[c] && sy3[c]) |=> cap_q[c] == $past(timer_i));
    p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      trig[c] |=> irq_o[c]);
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o[c] && !(bus_we && bus_addr == AW'(FLAG_ADDR) && bus_wdata[c])) |=> irq_o[c]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= (irq_q & ~clr) | trig;
  end
  assign irq_o = irq_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(FLAG_ADDR)) bus_rdata[NCH-1:0] = irq_q;
    for (int c = 0; c < NCH; c++) begin
      if (bus_addr == AW'(2 * c))     bus_rdata = cap_q[c][7:0];
      if (bus_addr == AW'(2 * c + 1)) bus_rdata = 8'(cap_q[c] >> 8);
    end
  end
endmodule

// File: tb/sim_cap4_unit.sv
`timescale 1ns/1ps
module sim_cap4_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  pin_i = '0;
  logic [15:0] timer_i = '0;
  logic [3:0]  sw_mode = '0;
  logic [3:0]  fall_edge = '0;
  logic        bus_we = 0;
  logic [3:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [63:0] cap_o;
  logic [3:0]  irq_o;

  int checks = 0;
  int fails = 0;

  cap4_unit u0 (.clk(clk), .rst_n(rst_n), .pin_i(pin_i), .timer_i(timer_i),
    .sw_mode(sw_mode), .fall_edge(fall_edge), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_o(cap_o), .irq_o(irq_o));

  always #4 clk = ~clk;

  // {channel[1:0], write_mode, falling, timer[15:0]}
  localparam logic [19:0] VEC [8] = '{
    {2'd0, 1'b0, 1'b0, 16'h1234}, {2'd1, 1'b0, 1'b1, 16'hA5C3},
    {2'd2, 1'b1, 1'b0, 16'h0F0F}, {2'd3, 1'b0, 1'b0, 16'hFFFF},
    {2'd0, 1'b1, 1'b0, 16'h8001}, {2'd1, 1'b1, 1'b1, 16'h7E11},
    {2'd2, 1'b0, 1'b1, 16'h4321}, {2'd3, 1'b1, 1'b0, 16'h0001}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    clocks(1);
    bus_we = 0;
  endtask

  function automatic logic [15:0] cap_of(input int c);
    return cap_o[c*16 +: 16];
  endfunction

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] keep;
    clocks(3);
    check("R1 caps after reset", cap_o[31:0], 32'h0);
    check("R1 caps after reset hi", cap_o[63:32], 32'h0);
    check("R1 flags after reset", {28'h0, irq_o}, 32'h0);
    bus_addr = 4'd8; #1;
    check("R1 flag read after reset", {24'h0, bus_rdata}, 32'h0);
    rst_n = 1;
    clocks(1);

    for (int i = 0; i < 8; i++) begin
      int ch;
      logic [15:0] tv;
      ch = int'(VEC[i][19:18]);
      tv = VEC[i][15:0];
      sw_mode[ch] = VEC[i][17];
      fall_edge[ch] = VEC[i][16];
      bus_write(4'd8, 8'h0F);
      if (VEC[i][17]) begin
        timer_i = tv;
        bus_write(4'(2 * ch), ~tv[7:0]);
        check("R4 write-mode capture", {16'h0, cap_of(ch)}, {16'h0, tv});
      end else if (!VEC[i][16]) begin
        timer_i = tv; pin_i[ch] = 1; clocks(4);
        timer_i = ~tv; pin_i[ch] = 0; clocks(4);
        check("R2 rising capture, falling ignored", {16'h0, cap_of(ch)}, {16'h0, tv});
      end else begin
        timer_i = ~tv; pin_i[ch] = 1; clocks(4);
        timer_i = tv; pin_i[ch] = 0; clocks(4);
        check("R3 falling capture, rising ignored", {16'h0, cap_of(ch)}, {16'h0, tv});
      end
      check("R8 flag set by capture", {28'h0, irq_o}, 32'(1 << ch));
      bus_addr = 4'(2 * ch); #1;
      check("R7 low byte read", {24'h0, bus_rdata}, {24'h0, tv[7:0]});
      bus_addr = 4'(2 * ch + 1); #1;
      check("R7 high byte read", {24'h0, bus_rdata}, {24'h0, tv[15:8]});
    end

    // R9 latency
    sw_mode = 4'b0000; fall_edge = 4'b0000;
    keep = cap_of(0);
    timer_i = 16'hAAAA; pin_i[0] = 1;
    clocks(1); timer_i = 16'hBBBB;
    clocks(1);
    check("R9 unchanged after second edge", {16'h0, cap_of(0)}, {16'h0, keep});
    timer_i = 16'hCCCC;
    clocks(1);
    check("R9 capture at third edge", {16'h0, cap_of(0)}, 32'h0000CCCC);
    pin_i[0] = 0; clocks(4);

    // R6 hold while timer runs
    for (int k = 0; k < 20; k++) begin timer_i = timer_i + 16'd37; clocks(1); end
    check("R6 hold with running timer", {16'h0, cap_of(0)}, 32'h0000CCCC);

    // R5 pin-mode channel ignores low-byte write
    bus_write(4'd8, 8'h0F);
    keep = cap_of(1);
    timer_i = 16'h5555;
    bus_write(4'd2, 8'h99);
    check("R5 write ignored in pin mode", {16'h0, cap_of(1)}, {16'h0, keep});
    check("R5 no flag from ignored write", {28'h0, irq_o}, 32'h0);

    // R5 high byte write ignored
    sw_mode[2] = 1;
    keep = cap_of(2);
    bus_write(4'd5, 8'h77);
    check("R5 high byte write ignored", {16'h0, cap_of(2)}, {16'h0, keep});

    // R5 write-mode channel ignores pin
    sw_mode[3] = 1;
    keep = cap_of(3);
    timer_i = 16'h6666; pin_i[3] = 1; clocks(4);
    pin_i[3] = 0; clocks(4);
    check("R5 pin ignored in write mode", {16'h0, cap_of(3)}, {16'h0, keep});
    check("R5 no flag from ignored pin", {28'h0, irq_o}, 32'h0);

    // R8 selective clear and R7 flag read
    sw_mode = 4'b0011;
    bus_write(4'd0, 8'h00);
    bus_write(4'd2, 8'h00);
    bus_write(4'd8, 8'h01);
    check("R8 selective clear", {28'h0, irq_o}, 32'h2);
    bus_addr = 4'd8; #1;
    check("R7 flag read", {24'h0, bus_rdata}, 32'h2);
    bus_addr = 4'd9; #1;
    check("R7 unused address reads zero", {24'h0, bus_rdata}, 32'h0);

    // R8 capture wins over clear in same cycle
    sw_mode[2] = 0; fall_edge[2] = 0;
    pin_i[2] = 1;
    clocks(2);
    bus_write(4'd8, 8'h04);
    check("R8 set beats clear", {31'h0, irq_o[2]}, 32'h1);
    pin_i[2] = 0; clocks(4);
    bus_write(4'd8, 8'h04);
    check("R8 clear by write of 1", {31'h0, irq_o[2]}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule